// File: doc/BRIEF.md
# Lens Actuator Control Register Bank

This block is the register file behind a voice-coil lens actuator. A host reaches it over a simple parallel register bus that stands in for a serial target front end. The bus offers a one-byte write, a two-byte write to two consecutive addresses, and a one-byte read. The bank holds a power and ringing control byte, a DAC code split over two addresses, a byte for the settling mode and clock divider, and a settling time byte. It drives the assembled DAC code and the mode fields straight to the actuator.

The DAC code is 10 bits wide. Its two top bits live at one address and its low byte at the next. The low byte is the commit point: writing it applies the staged top bits and the new low byte as one code. After power-up, and again each time power-down is released, the bank spends a fixed operating delay not ready. During that window writes are dropped. Reads, including a status read that reports the window, are still served. While power-down is set, the code driven to the actuator is zero.

Top module: `lens_vcm_regbank`

## Requirements
- R1: After a synchronous reset the bank holds power-down 0, ringing mode 0, DAC code 0, settling mode 0, divider select 0 and settling time 0x20, and ready is low.
- R2: ready rises exactly OPR_CYCLES clock edges after reset is released.
- R3: Any write accepted while ready is low leaves every register and every output unchanged.
- R4: A write to 0x02 that changes bit 0 from 1 to 0 drops ready on that edge for OPR_CYCLES edges. A write that sets bit 0, or leaves it at 0, does not start a window.
- R5: Address 0x02 bit 0 drives power_down (1 = powered down) and bit 1 drives ring_mode (1 = ringing control, 0 = direct).
- R6: Address 0x03 bits [1:0] stage DAC bits [9:8] without changing dac_code. A write to 0x04 sets dac_code to {staged bits, written byte} on that edge.
- R7: A two-byte write puts wdata[15:8] at addr and wdata[7:0] at addr+1. At 0x03 this updates both halves of the DAC code on one edge.
- R8: While power_down is 1, dac_code is 0. Clearing power_down drives the last applied code again.
- R9: Address 0x06 bits [7:5] drive aac_mode and bits [2:0] drive presc_sel.
- R10: Address 0x07 bits [5:0] drive aac_time.
- R11: Address 0x05 is read-only. Its bit 0 reads 1 while ready is low.
- R12: rdata is valid one edge after rd_en, also while ready is low. Unused bits read 0, and addresses outside 0x02..0x07 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_two | input | 1 | With wr_en: two-byte write |
| addr | input | 8 | Register address |
| wdata | input | 16 | Write data; single writes use [7:0] |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| ready | output | 1 | High when writes are accepted |
| power_down | output | 1 | Power-down state |
| ring_mode | output | 1 | Ringing-control mode select |
| dac_code | output | DAC_W | Current code driven to the actuator |
| aac_mode | output | 3 | Settling mode field |
| presc_sel | output | 3 | Clock divider select |
| aac_time | output | 6 | Settling time field |

## Verification
Directed writes test the DAC staging three ways: the top bits alone, which must leave dac_code unchanged; the low byte alone, which must commit; and a two-byte write, which must commit both halves at once. Power-down is toggled in both directions and written with its current value, which shows which transitions start a not-ready window. Writes and reads land inside and outside that window, and reads cover unmapped and read-only addresses. A seeded random mix of single and two-byte writes over and around the mapped range, with power-down flips among them, is compared after every transaction against a model written from the requirements.

// File: rtl/lvr_pkg.sv
package lvr_pkg;
  localparam int REG_BASE  = 2;
  localparam int REG_COUNT = 6;
  // Index into the per-register write-enable array (address minus REG_BASE).
  localparam int IX_CTRL = 0;
  localparam int IX_DHI  = 1;
  localparam int IX_DLO  = 2;
  localparam int IX_STAT = 3;
  localparam int IX_MODE = 4;
  localparam int IX_TIME = 5;
  localparam logic [5:0] TIME_RST = 6'h20;

  typedef struct packed {
    logic [2:0] mode;
    logic [1:0] pad;
    logic [2:0] presc;
  } mode_byte_t;
endpackage

// File: rtl/lvr_lane_sel.sv
module lvr_lane_sel #(
  parameter logic [7:0] TARGET = 8'h00
) (
  input  logic        wr_ok,
  input  logic        wr_two,
  input  logic [7:0]  addr,
  input  logic [15:0] wdata,
  output logic        hit,
  output logic [7:0]  byte_o
);
  logic [7:0] addr_nxt;
  logic       lane0, lane1;

  always_comb begin
    addr_nxt = addr + 8'd1;
    lane0    = wr_ok && (addr == TARGET);
    lane1    = wr_ok && wr_two && (addr_nxt == TARGET);
    hit      = lane0 || lane1;
    if (lane1)       byte_o = wdata[7:0];
    else if (wr_two) byte_o = wdata[15:8];
    else             byte_o = wdata[7:0];
  end
endmodule

// File: rtl/lvr_ready_timer.sv
module lvr_ready_timer #(
  parameter int OPR_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic ready
);
  localparam int CW = $clog2(OPR_CYCLES + 2);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt   <= CW'(OPR_CYCLES);
      ready <= 1'b0;
    end else if (cnt != '0) begin
      cnt   <= cnt - 1'b1;
      ready <= (cnt == CW'(1));
    end
  end

  // Independent edge counter for checking the window length.
  logic [CW-1:0] chk_cnt;
  always_ff @(posedge clk) begin
    if (rst || restart)                  chk_cnt <= '0;
    else if (chk_cnt != CW'(OPR_CYCLES + 1)) chk_cnt <= chk_cnt + 1'b1;
  end

  assert_window_len_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> chk_cnt == CW'(OPR_CYCLES));

  assert_fall_only_on_restart_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(ready) |-> $past(restart));
endmodule

// File: rtl/lvr_dac_stage.sv
module lvr_dac_stage #(
  parameter int DAC_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hi_we,
  input  logic [7:0]       hi_byte,
  input  logic             lo_we,
  input  logic [7:0]       lo_byte,
  input  logic             pd_next,
  output logic [DAC_W-9:0] hi_q,
  output logic [7:0]       lo_q,
  output logic [DAC_W-1:0] dac_o
);
  localparam int MSB_W = DAC_W - 8;

  logic [MSB_W-1:0] hi_next;
  logic [DAC_W-1:0] applied_q, applied_next;

  always_comb begin
    hi_next      = hi_we ? hi_byte[MSB_W-1:0] : hi_q;
    applied_next = lo_we ? {hi_next, lo_byte} : applied_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q      <= '0;
      lo_q      <= '0;
      applied_q <= '0;
      dac_o     <= '0;
    end else begin
      hi_q      <= hi_next;
      if (lo_we) lo_q <= lo_byte;
      applied_q <= applied_next;
      dac_o     <= pd_next ? '0 : applied_next;
    end
  end

  assert_hi_only_holds_code_R6: assert property (@(posedge clk) disable iff (rst)
    (hi_we && !lo_we) |=> $stable(applied_q));

  assert_lo_commits_R6: assert property (@(posedge clk) disable iff (rst)
    lo_we |=> applied_q[7:0] == $past(lo_byte));
endmodule

// File: rtl/lens_vcm_regbank.sv
module lens_vcm_regbank #(
  parameter int OPR_CYCLES = 1000,
  parameter int DAC_W      = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_two,
  input  logic [7:0]       addr,
  input  logic [15:0]      wdata,
  input  logic             rd_en,
  output logic [7:0]       rdata,
  output logic             ready,
  output logic             power_down,
  output logic             ring_mode,
  output logic [DAC_W-1:0] dac_code,
  output logic [2:0]       aac_mode,
  output logic [2:0]       presc_sel,
  output logic [5:0]       aac_time
);
  import lvr_pkg::*;
  localparam int MSB_W = DAC_W - 8;

  logic                 wr_ok;
  logic [REG_COUNT-1:0] hit;
  logic [7:0]           byte_a [REG_COUNT];
  logic                 pd_next, restart;
  logic [MSB_W-1:0]     hi_q;
  logic [7:0]           lo_q;
  mode_byte_t           mode_in;

  assign wr_ok = wr_en && ready;

  for (genvar i = 0; i < REG_COUNT; i++) begin : g_lane
    lvr_lane_sel #(.TARGET(8'(REG_BASE + i))) u_sel (
      .wr_ok (wr_ok),
      .wr_two(wr_two),
      .addr  (addr),
      .wdata (wdata),
      .hit   (hit[i]),
      .byte_o(byte_a[i])
    );
  end

  always_comb begin
    pd_next = hit[IX_CTRL] ? byte_a[IX_CTRL][0] : power_down;
    restart = hit[IX_CTRL] && power_down && !byte_a[IX_CTRL][0];
    mode_in = mode_byte_t'(byte_a[IX_MODE]);
  end

  lvr_ready_timer #(.OPR_CYCLES(OPR_CYCLES)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .restart(restart),
    .ready  (ready)
  );

  lvr_dac_stage #(.DAC_W(DAC_W)) u_dac (
    .clk    (clk),
    .rst    (rst),
    .hi_we  (hit[IX_DHI]),
    .hi_byte(byte_a[IX_DHI]),
    .lo_we  (hit[IX_DLO]),
    .lo_byte(byte_a[IX_DLO]),
    .pd_next(pd_next),
    .hi_q   (hi_q),
    .lo_q   (lo_q),
    .dac_o  (dac_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      power_down <= 1'b0;
      ring_mode  <= 1'b0;
      aac_mode   <= '0;
      presc_sel  <= '0;
      aac_time   <= TIME_RST;
    end else begin
      power_down <= pd_next;
      if (hit[IX_CTRL]) ring_mode <= byte_a[IX_CTRL][1];
      if (hit[IX_MODE]) begin
        aac_mode  <= mode_in.mode;
        presc_sel <= mode_in.presc;
      end
      if (hit[IX_TIME]) aac_time <= byte_a[IX_TIME][5:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (addr)
        8'h02:   rdata <= {6'b0, ring_mode, power_down};
        8'h03:   rdata <= 8'(hi_q);
        8'h04:   rdata <= lo_q;
        8'h05:   rdata <= {7'b0, !ready};
        8'h06:   rdata <= {aac_mode, 2'b0, presc_sel};
        8'h07:   rdata <= {2'b0, aac_time};
        default: rdata <= 8'h00;
      endcase
    end
  end

  assert_pd_zero_code_R8: assert property (@(posedge clk) disable iff (rst)
    power_down |-> dac_code == '0);

  assert_locked_writes_R3: assert property (@(posedge clk) disable iff (rst)
    (!ready && wr_en) |=> $stable(dac_code) && $stable(aac_time) &&
                          $stable(aac_mode) && $stable(power_down));

  assert_unmapped_read_R12: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (addr < 8'h02 || addr > 8'h07)) |=> rdata == 8'h00);

  assert_status_readonly_R11: assert property (@(posedge clk) disable iff (rst)
    (hit[IX_STAT] && !hit[IX_CTRL] && !hit[IX_MODE]) |=> $stable(power_down) && $stable(aac_mode));
endmodule

// File: tb/lens_vcm_regbank_tb_top.sv
module lens_vcm_regbank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, wr_two = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [7:0]  rdata;
  logic        ready, power_down, ring_mode;
  logic [9:0]  dac_code;
  logic [2:0]  aac_mode, presc_sel;
  logic [5:0]  aac_time;

  always #(CLK_PERIOD/2) clk = ~clk;

  lens_vcm_regbank #(.OPR_CYCLES(N), .DAC_W(10)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_two(wr_two), .addr(addr),
    .wdata(wdata), .rd_en(rd_en), .rdata(rdata), .ready(ready),
    .power_down(power_down), .ring_mode(ring_mode), .dac_code(dac_code),
    .aac_mode(aac_mode), .presc_sel(presc_sel), .aac_time(aac_time)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // Reference model, written from the requirements.
  int         m_left;
  logic       m_pd, m_ring;
  logic [1:0] m_msb;
  logic [7:0] m_lsb;
  logic [9:0] m_app;
  logic [2:0] m_mode, m_presc;
  logic [5:0] m_time;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    if (m_left > 0) m_left--;
  endtask

  task automatic model_byte(logic [7:0] a, logic [7:0] d);
    case (a)
      8'h02: begin
        if (m_pd && !d[0]) m_left = N;
        m_pd = d[0]; m_ring = d[1];
      end
      8'h03: m_msb = d[1:0];
      8'h04: begin m_lsb = d; m_app = {m_msb, d}; end
      8'h06: begin m_mode = d[7:5]; m_presc = d[2:0]; end
      8'h07: m_time = d[5:0];
      default: ;
    endcase
  endtask

  function automatic logic [7:0] exp_rd(logic [7:0] a, bit busy);
    case (a)
      8'h02: return {6'b0, m_ring, m_pd};
      8'h03: return {6'b0, m_msb};
      8'h04: return m_lsb;
      8'h05: return {7'b0, busy};
      8'h06: return {m_mode, 2'b0, m_presc};
      8'h07: return {2'b0, m_time};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check_outs(string req);
    chk({req, " dac_code"}, 32'(dac_code), 32'(m_pd ? 10'd0 : m_app));
    chk({req, " power_down"}, 32'(power_down), 32'(m_pd));
    chk({req, " ring_mode"}, 32'(ring_mode), 32'(m_ring));
    chk({req, " aac_mode"}, 32'(aac_mode), 32'(m_mode));
    chk({req, " presc_sel"}, 32'(presc_sel), 32'(m_presc));
    chk({req, " aac_time"}, 32'(aac_time), 32'(m_time));
    chk({req, " ready"}, 32'(ready), 32'(m_left == 0));
  endtask

  task automatic bus_write(logic [7:0] a, logic [15:0] d, bit two);
    bit acc;
    acc = (m_left == 0);
    addr = a; wdata = d; wr_two = two; wr_en = 1'b1;
    cyc();
    wr_en = 1'b0; wr_two = 1'b0;
    if (acc) begin
      if (two) begin
        model_byte(a, d[15:8]);
        model_byte(a + 8'd1, d[7:0]);
      end else begin
        model_byte(a, d[7:0]);
      end
    end
  endtask

  task automatic bus_read(logic [7:0] a, string req);
    bit busy;
    busy = (m_left != 0);
    addr = a; rd_en = 1'b1;
    cyc();
    rd_en = 1'b0;
    chk(req, 32'(rdata), 32'(exp_rd(a, busy)));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_left = N; m_pd = 0; m_ring = 0; m_msb = 0; m_lsb = 0; m_app = 0;
    m_mode = 0; m_presc = 0; m_time = 6'h20;
    // R1: reset state
    repeat (3) @(negedge clk);
    check_outs("R1");
    rst = 1'b0;
    m_left = N;
    // R3: write during power-up window is dropped
    bus_write(8'h07, 16'h0011, 1'b0);
    check_outs("R3");
    // R11 / R12: status read while not ready
    bus_read(8'h05, "R11 status busy");
    // R2: ready rises exactly N edges after release
    while (m_left > 1) begin
      cyc();
      chk("R2 ready low in window", 32'(ready), 32'd0);
    end
    cyc();
    chk("R2 ready after window", 32'(ready), 32'd1);
    // R5 / R4: ring mode, pd written 0 while already 0
    bus_write(8'h02, 16'h00FE, 1'b0);
    check_outs("R5 R4");
    bus_read(8'h02, "R12 ctrl unused bits");
    // R6: staged top bits
    bus_write(8'h03, 16'h0003, 1'b0);
    check_outs("R6 hi only");
    bus_write(8'h04, 16'h005A, 1'b0);
    chk("R6 commit", 32'(dac_code), 32'h35A);
    bus_write(8'h03, 16'h00FD, 1'b0);
    chk("R6 hi stage holds", 32'(dac_code), 32'h35A);
    bus_read(8'h03, "R6 hi readback");
    // R7: two-byte write
    bus_write(8'h03, 16'h02A5, 1'b1);
    chk("R7 two-byte commit", 32'(dac_code), 32'h2A5);
    check_outs("R7");
    // R8 / R4: power-down forces zero, no window on set
    bus_write(8'h02, 16'h0001, 1'b0);
    chk("R8 pd zero", 32'(dac_code), 32'd0);
    chk("R4 set pd no window", 32'(ready), 32'd1);
    bus_write(8'h04, 16'h0033, 1'b0);
    chk("R8 pd still zero", 32'(dac_code), 32'd0);
    bus_write(8'h02, 16'h0000, 1'b0);
    chk("R8 restore", 32'(dac_code), 32'h233);
    chk("R4 window starts", 32'(ready), 32'd0);
    bus_write(8'h06, 16'h00FF, 1'b0);
    check_outs("R3 locked after pd clear");
    while (m_left > 0) cyc();
    chk("R4 ready back", 32'(ready), 32'd1);
    // R9 / R10
    bus_write(8'h06, 16'h00BF, 1'b0);
    check_outs("R9");
    bus_read(8'h06, "R9 readback");
    bus_write(8'h07, 16'h00FF, 1'b0);
    check_outs("R10");
    bus_read(8'h07, "R10 readback");
    // R11: status is read-only
    bus_write(8'h05, 16'h00FF, 1'b0);
    check_outs("R11 write ignored");
    bus_read(8'h05, "R11 status ready");
    // R12: unmapped addresses
    bus_read(8'h00, "R12 addr 00");
    bus_read(8'h08, "R12 addr 08");
    bus_read(8'hFF, "R12 addr FF");
    // Random mix
    for (int k = 0; k < 400; k++) begin
      logic [7:0]  ra;
      logic [15:0] rd;
      bit          two;
      ra  = ($urandom % 4 == 0) ? 8'($urandom) : 8'(1 + $urandom % 8);
      rd  = 16'($urandom);
      two = ($urandom % 3 == 0);
      bus_write(ra, rd, two);
      check_outs("R3 R6 R7 R8 random");
      if ($urandom % 4 == 0) bus_read(8'(1 + $urandom % 8), "R12 random read");
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule